// File: doc/BRIEF.md
# D4 Receive Robbed-Bit Signaling Capture

This block sits behind a T1 receive framer that is already locked to the 12-frame D4 superframe. Each cycle with `ts_valid` high, the block is given three things:

- one received channel byte,
- the index of its timeslot,
- the index of the frame within the superframe.

From these it gathers the robbed signaling bits of all channels. The A bit is taken in the sixth frame and the B bit in the twelfth frame. The block commits a full superframe of signaling once the last timeslot of the twelfth frame has been seen.

Committed signaling is kept two superframes deep and can be read by a host.

- The newest superframe lives in an upper bank.
- On each commit, the superframe before it moves into a lower bank.

Two sticky status flags mark events for the host:

- one flag marks every superframe update;
- one flag marks a change in any signaling bit.

Each flag has a mask bit, and the interrupt line is the OR of the unmasked flags. While the framer reports loss of sync, nothing is captured and the history is frozen.

Top module: `robsig_capture`

## Requirements
- R1: When a superframe is committed, its signaling is written into register addresses 6 to 11. Commit happens one cycle after the last timeslot (index 23) of frame index 11 is accepted, and the new value is readable two cycles after that timeslot.
- R2: On every commit, the former contents of addresses 6 to 11 move to addresses 0 to 5, and the earlier contents of addresses 0 to 5 are lost.
- R3: Within each bank of six, the offsets are laid out as follows. Reading an address from 12 to 15 returns 0, and `rd_data` reflects `rd_addr` one clock later.

  | Offset | Contents | Bit order |
  |---|---|---|
  | 0 | A bits of channels 1–8 | lowest channel in bit 0 |
  | 1 | A bits of channels 9–16 | lowest channel in bit 0 |
  | 2 | A bits of channels 17–24 | lowest channel in bit 0 |
  | 3 | B bits of channels 1–8 | lowest channel in bit 0 |
  | 4 | B bits of channels 9–16 | lowest channel in bit 0 |
  | 5 | B bits of channels 17–24 | lowest channel in bit 0 |

- R4: A bits are bit 0 of the channel bytes in frame index 5, and B bits are bit 0 of the channel bytes in frame index 11. Timeslot index n carries channel n+1. Bytes in all other frames, and bits 7..1 of every byte, have no effect.
- R5: The superframe flag (`sf_flag`) is set on every commit.
- R6: The change flag (`chg_flag`) is set on a commit whose 48 bits differ in any position from the prior contents of addresses 6 to 11. It is never set by the first commit after reset.
- R7: Both flags are sticky. Writing with `clr_we` high and a 1 in `clr_bits` clears the matching flag (bit 0 for the superframe flag, bit 1 for the change flag). If a set and a clear arrive in the same cycle, the set wins.
- R8: `irq` equals the OR of (`sf_flag` AND `irq_mask[0]`) and (`chg_flag` AND `irq_mask[1]`), and is valid in the same cycle as the flags.
- R9: While `sync_lost` is high, no commit happens, no flag is set and all twelve registers keep their values.
- R10: A superframe during which `sync_lost` was high at any point is discarded. Capture resumes only with a superframe whose frame 0, timeslot 0 is accepted in sync.
- R11: After reset, all registers, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | Channel byte present this cycle |
| ts_idx | input | 5 | Timeslot index 0..23 |
| frame_idx | input | 4 | Frame index 0..11 in the superframe |
| ts_byte | input | 8 | Received channel byte |
| sync_lost | input | 1 | Receiver out of frame sync |
| rd_addr | input | 4 | Host read address 0..11 |
| rd_data | output | 8 | Registered read data |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 2 | Write-1-to-clear: bit0 superframe, bit1 change |
| irq_mask | input | 2 | Interrupt enables: bit0 superframe, bit1 change |
| sf_flag | output | 1 | Sticky superframe-update flag |
| chg_flag | output | 1 | Sticky signaling-change flag |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same clock: a commit that sets a flag, and a host write-1-to-clear of that same flag. The bench provokes this by holding `clr_we` with both bits set across the exact edge at which the commit's set pulses reach the status register. It then judges that both flags read 1 afterwards, which shows the set won, and that a later clear with no commit pending brings them to 0. A sweep over several superframes covers three further cases against a bench-side model of the two banks: repeated patterns, changed patterns and rotating masks. Separate superframes cover loss of sync mid-way, loss of sync throughout, and the recovery after it.

// File: rtl/robsig_pkg.sv
package robsig_pkg;
  localparam int BYTE_W  = 8;
  localparam int FLAG_N  = 2;
  localparam int FLG_SF  = 0;
  localparam int FLG_CHG = 1;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/robsig_collect.sv
module robsig_collect #(
  parameter int NUM_CH  = 24,
  parameter int FRAMES  = 12,
  parameter int A_FRAME = 5,
  parameter int B_FRAME = 11,
  parameter int TSW     = $clog2(NUM_CH),
  parameter int FW      = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ts_valid,
  input  logic [TSW-1:0]    ts_idx,
  input  logic [FW-1:0]     frame_idx,
  input  logic              sig_bit,
  input  logic              sync_lost,
  output logic              commit_o,
  output logic [NUM_CH-1:0] a_o,
  output logic [NUM_CH-1:0] b_o
);
  localparam logic [TSW-1:0] LAST_TS = TSW'(NUM_CH - 1);
  localparam logic [FW-1:0]  FA      = FW'(A_FRAME);
  localparam logic [FW-1:0]  FB      = FW'(B_FRAME);

  logic [NUM_CH-1:0] a_st, b_st, a_nx, b_nx;
  logic              whole_q;
  logic              take, start, last;

  assign take  = ts_valid && !sync_lost && (ts_idx <= LAST_TS);
  assign start = take && (frame_idx == '0) && (ts_idx == '0);
  assign last  = take && (frame_idx == FB) && (ts_idx == LAST_TS);

  always_comb begin
    a_nx = a_st;
    b_nx = b_st;
    if (take && frame_idx == FA) a_nx[ts_idx] = sig_bit;
    if (take && frame_idx == FB) b_nx[ts_idx] = sig_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_st     <= '0;
      b_st     <= '0;
      a_o      <= '0;
      b_o      <= '0;
      whole_q  <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      a_st     <= a_nx;
      b_st     <= b_nx;
      commit_o <= last && whole_q;
      if (sync_lost)  whole_q <= 1'b0;
      else if (start) whole_q <= 1'b1;
      if (last) begin
        a_o <= a_nx;
        b_o <= b_nx;
      end
    end
  end

  // R9: no commit emerges from a cycle spent out of sync
  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    sync_lost |=> !commit_o);
  // R10: a commit always follows an in-sync final timeslot
  p_commit_src_r10: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(ts_valid) && !$past(sync_lost));
endmodule

// File: rtl/robsig_bank.sv
module robsig_bank
  import robsig_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int NGRP   = (NUM_CH + BYTE_W - 1) / BYTE_W,
  parameter int HALF   = 2 * NGRP,
  parameter int NREG   = 2 * HALF,
  parameter int AW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [NUM_CH-1:0] a_i,
  input  logic [NUM_CH-1:0] b_i,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              sf_set,
  output logic              chg_set
);
  localparam int VW = 2 * NUM_CH;
  localparam logic [AW-1:0] NREG_A = AW'(NREG);

  logic [VW-1:0] new_vec, old_vec, in_vec;
  logic          primed;
  logic [BYTE_W-1:0] new_b [HALF];
  logic [BYTE_W-1:0] old_b [HALF];
  logic [BYTE_W-1:0] bank_rd [NREG];

  assign in_vec = {b_i, a_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      new_vec <= '0;
      old_vec <= '0;
      primed  <= 1'b0;
      sf_set  <= 1'b0;
      chg_set <= 1'b0;
    end else begin
      sf_set  <= commit_i;
      chg_set <= commit_i && primed && (in_vec != new_vec);
      if (commit_i) begin
        old_vec <= new_vec;
        new_vec <= in_vec;
        primed  <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < HALF; k++) begin : g_reg
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      localparam int G   = k % NGRP;
      localparam int SIG = k / NGRP;
      localparam int CH  = G * BYTE_W + i;
      if (CH < NUM_CH) begin : g_map
        assign new_b[k][i] = new_vec[SIG*NUM_CH + CH];
        assign old_b[k][i] = old_vec[SIG*NUM_CH + CH];
      end else begin : g_pad
        assign new_b[k][i] = 1'b0;
        assign old_b[k][i] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < HALF; k++) begin
      bank_rd[k]        = old_b[k];
      bank_rd[k + HALF] = new_b[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_addr < NREG_A) ? bank_rd[rd_addr] : '0;
  end

  // R1: banks only move on a commit
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(new_vec) && $stable(old_vec));
  // R2: the lower bank receives the former upper bank
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> old_vec == $past(new_vec));
  // R6: a change report only accompanies an update
  p_chg_with_update_r6: assert property (@(posedge clk) disable iff (rst)
    chg_set |-> sf_set);
endmodule

// File: rtl/robsig_status.sv
module robsig_status
  import robsig_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sf_set_i,
  input  logic      chg_set_i,
  input  logic      clr_we,
  input  flag_vec_t clr_bits,
  input  flag_vec_t irq_mask,
  output flag_vec_t flags,
  output logic      irq
);
  flag_vec_t set_v, clr_v, nxt;

  always_comb begin
    set_v          = '0;
    set_v[FLG_SF]  = sf_set_i;
    set_v[FLG_CHG] = chg_set_i;
    clr_v          = clr_we ? clr_bits : '0;
    nxt            = (flags & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nxt;
      irq   <= |(nxt & irq_mask);
    end
  end

  // R5: every update leaves the superframe flag raised
  p_sf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    sf_set_i |=> flags[FLG_SF]);
  // R7: clear without a competing set empties the change flag
  p_clr_r7: assert property (@(posedge clk) disable iff (rst)
    clr_we && clr_bits[FLG_CHG] && !chg_set_i |=> !flags[FLG_CHG]);
  // R8: masked-off flags cannot drive the interrupt
  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(flags & $past(irq_mask)));
endmodule

// File: rtl/robsig_capture.sv
module robsig_capture
  import robsig_pkg::*;
#(
  parameter int NUM_CH  = 24,
  parameter int FRAMES  = 12,
  parameter int A_FRAME = 5,
  parameter int B_FRAME = 11,
  parameter int TSW     = $clog2(NUM_CH),
  parameter int FW      = $clog2(FRAMES),
  parameter int AW      = $clog2(4 * ((NUM_CH + BYTE_W - 1) / BYTE_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ts_valid,
  input  logic [TSW-1:0]    ts_idx,
  input  logic [FW-1:0]     frame_idx,
  input  logic [BYTE_W-1:0] ts_byte,
  input  logic              sync_lost,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              clr_we,
  input  logic [1:0]        clr_bits,
  input  logic [1:0]        irq_mask,
  output logic              sf_flag,
  output logic              chg_flag,
  output logic              irq
);
  logic              commit;
  logic [NUM_CH-1:0] a_v, b_v;
  logic              sf_set, chg_set;
  flag_vec_t         flags;
  logic              unused_hi;

  assign unused_hi = ^ts_byte[BYTE_W-1:1];

  robsig_collect #(
    .NUM_CH(NUM_CH), .FRAMES(FRAMES), .A_FRAME(A_FRAME),
    .B_FRAME(B_FRAME), .TSW(TSW), .FW(FW)
  ) u_collect (
    .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_idx(ts_idx),
    .frame_idx(frame_idx), .sig_bit(ts_byte[0]), .sync_lost(sync_lost),
    .commit_o(commit), .a_o(a_v), .b_o(b_v)
  );

  robsig_bank #(.NUM_CH(NUM_CH), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .commit_i(commit), .a_i(a_v), .b_i(b_v),
    .rd_addr(rd_addr), .rd_data(rd_data), .sf_set(sf_set), .chg_set(chg_set)
  );

  robsig_status u_status (
    .clk(clk), .rst(rst), .sf_set_i(sf_set), .chg_set_i(chg_set),
    .clr_we(clr_we), .clr_bits(clr_bits), .irq_mask(irq_mask),
    .flags(flags), .irq(irq)
  );

  assign sf_flag  = flags[FLG_SF];
  assign chg_flag = flags[FLG_CHG];
endmodule

// File: tb/robsig_capture_bench.sv
module robsig_capture_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       ts_valid;
  logic [4:0] ts_idx;
  logic [3:0] frame_idx;
  logic [7:0] ts_byte;
  logic       sync_lost;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic       clr_we;
  logic [1:0] clr_bits;
  logic [1:0] irq_mask;
  logic       sf_flag, chg_flag, irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [47:0] mnew, mold;
  bit primed;

  always #10 clk = ~clk;

  robsig_capture u_robsig_capture (
    .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_idx(ts_idx),
    .frame_idx(frame_idx), .ts_byte(ts_byte), .sync_lost(sync_lost),
    .rd_addr(rd_addr), .rd_data(rd_data), .clr_we(clr_we),
    .clr_bits(clr_bits), .irq_mask(irq_mask), .sf_flag(sf_flag),
    .chg_flag(chg_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int seed, input bit bsel);
    logic [23:0] v;
    for (int c = 0; c < 24; c++)
      v[c] = 1'(((c * 5 + seed * 11 + (bsel ? 7 : 0)) * 13 >> 2) & 1);
    return v;
  endfunction

  function automatic logic [7:0] model_byte(input int k);
    logic [7:0]  r;
    logic [47:0] v;
    int kk, sig, g;
    v   = (k >= 6) ? mnew : mold;
    kk  = k % 6;
    sig = kk / 3;
    g   = kk % 3;
    for (int i = 0; i < 8; i++) r[i] = v[sig*24 + g*8 + i];
    return r;
  endfunction

  task automatic read_reg(input int a, output logic [7:0] d);
    rd_addr = 4'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_bank(input string tag);
    logic [7:0] d;
    for (int k = 0; k < 12; k++) begin
      read_reg(k, d);
      chk($sformatf("%s reg%0d", tag, k), 32'(d), 32'(model_byte(k)));
    end
  endtask

  // lose: -1 none, 0..11 lose during that frame only, 99 whole superframe
  task automatic send_sf(input logic [23:0] a, input logic [23:0] b,
                         input int lose, input bit clr_now);
    for (int f = 0; f < 12; f++) begin
      for (int t = 0; t < 24; t++) begin
        @(negedge clk);
        ts_valid  = 1'b1;
        frame_idx = 4'(f);
        ts_idx    = 5'(t);
        sync_lost = (lose == 99) || (lose == f);
        ts_byte[7:1] = 7'((f * 37 + t * 19) & 127);
        if (f == 5)       ts_byte[0] = a[t];
        else if (f == 11) ts_byte[0] = b[t];
        else              ts_byte[0] = 1'((f + t) & 1);
      end
    end
    @(negedge clk);
    ts_valid  = 1'b0;
    sync_lost = 1'b0;
    @(negedge clk);
    if (clr_now) begin
      clr_we   = 1'b1;
      clr_bits = 2'b11;
    end
    @(negedge clk);
    clr_we   = 1'b0;
    clr_bits = 2'b00;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_we   = 1'b1;
    clr_bits = 2'b11;
    @(negedge clk);
    clr_we   = 1'b0;
    clr_bits = 2'b00;
    @(negedge clk);
  endtask

  task automatic run_sf(input int seed, input string tag);
    logic [23:0] a, b;
    bit exp_chg;
    a = pat(seed, 0);
    b = pat(seed, 1);
    exp_chg = primed && ({b, a} != mnew);
    send_sf(a, b, -1, 0);
    mold   = mnew;
    mnew   = {b, a};
    primed = 1;
    chk({tag, " R5 sf_flag"}, 32'(sf_flag), 32'd1);
    chk({tag, " R6 chg_flag"}, 32'(chg_flag), 32'(exp_chg));
    chk({tag, " R8 irq"}, 32'(irq),
        32'((irq_mask[0] & 1'b1) | (irq_mask[1] & exp_chg)));
    check_bank({tag, " R1 R2 R3 R4 bank"});
    clear_flags();
    chk({tag, " R7 flags cleared"}, 32'({chg_flag, sf_flag}), 32'd0);
    chk({tag, " R8 irq cleared"}, 32'(irq), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; ts_valid = 0; ts_idx = 0; frame_idx = 0; ts_byte = 0;
    sync_lost = 0; rd_addr = 0; clr_we = 0; clr_bits = 0; irq_mask = 2'b11;
    mnew = '0; mold = '0; primed = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 sf_flag reset", 32'(sf_flag), 32'd0);
    chk("R11 chg_flag reset", 32'(chg_flag), 32'd0);
    chk("R11 irq reset", 32'(irq), 32'd0);
    check_bank("R11 bank reset");

    run_sf(1, "first");

    for (int s = 2; s < 10; s++) begin
      irq_mask = 2'(s);
      run_sf((s % 3 == 0) ? s - 1 : s, $sformatf("sweep%0d", s));
    end
    irq_mask = 2'b11;

    // R10: loss mid-superframe discards it, flags stay clear
    send_sf(pat(20, 0), pat(20, 1), 7, 0);
    chk("R10 partial no sf_flag", 32'(sf_flag), 32'd0);
    chk("R10 partial no chg_flag", 32'(chg_flag), 32'd0);
    check_bank("R10 partial bank held");

    // R9: loss throughout
    send_sf(pat(21, 0), pat(21, 1), 99, 0);
    chk("R9 frozen no flags", 32'({chg_flag, sf_flag}), 32'd0);
    chk("R9 frozen no irq", 32'(irq), 32'd0);
    check_bank("R9 frozen bank held");

    // R10: capture resumes with a clean superframe
    run_sf(22, "R10 resume");

    // R7: set and clear in the same cycle, set wins
    begin
      logic [23:0] a, b;
      a = pat(23, 0);
      b = pat(23, 1);
      send_sf(a, b, -1, 1);
      mold = mnew;
      mnew = {b, a};
      chk("R7 set beats clear sf", 32'(sf_flag), 32'd1);
      chk("R7 set beats clear chg", 32'(chg_flag), 32'd1);
      check_bank("R7 collision bank");
      clear_flags();
      chk("R7 later clear", 32'({chg_flag, sf_flag}), 32'd0);
    end

    // R3: out-of-range addresses
    for (int k = 12; k < 16; k++) begin
      read_reg(k, d);
      chk($sformatf("R3 addr%0d zero", k), 32'(d), 32'd0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule